// File: doc/BRIEF.md
# Cascadable Dual-Channel 8-bit Timer

Two 8-bit up-counters, each with a pair of compare registers, sit behind a small register write port. Each channel counts on a pulse from one of six taps of a shared free-running divider of the system clock, or on the rising edge of its own external clock pin. A channel can return to zero when one of its compare values is reached, or on the rising edge of its external reset pin. The channel drives one waveform pin from the two compare events. It keeps three sticky event flags for compare A, compare B and overflow, and each flag has its own interrupt enable.

The two channels can be joined. In wide mode the two counters form one 16-bit count: channel 1 holds the low byte and channel 0 holds the high byte. In event-count mode channel 1 counts the compare-A events of channel 0. A compare-A event can also send a one-cycle start pulse to an analog-to-digital converter.

Registers use byte offsets. Bit 3 of the address selects the channel and bits 2:0 select the register:
- 0 is control: clock select [2:0], clear select [4:3], interrupt enables [7:5] for A, B and overflow.
- 1 is waveform control: A action [1:0], B action [3:2], converter trigger enable [4].
- 2 is compare A.
- 3 is compare B.
- 5 is the event flags, cleared by writing 1. Bit 0 is compare A, bit 1 is compare B, bit 2 is overflow.
- 6 writes the counter.
- Address 4 of channel 0 holds the cascade mode [1:0].

Top module: `tmr8_dual`

## Requirements
- R1: After reset every counter reads 0, every waveform pin is low, no interrupt output is high and the converter trigger is low.
- R2: Clock select codes 1 to 6 count once every 2, 8, 32, 64, 1024 and 8192 system clocks. Code 0 stops the counter.
- R3: Clock select code 7 counts once per rising edge of that channel's external clock pin. The pin passes through a two-flop synchronizer.
- R4: A compare event occurs on a count enable while the counter equals a compare value. With clear select 1 (compare A) or 2 (compare B), that count enable loads 0 instead of incrementing. Clear select 0 never clears.
- R5: With clear select 3, a rising edge on the channel's external reset pin clears the counter. With any other clear select, that pin has no effect.
- R6: Each compare event applies its 2-bit action to the waveform pin: 0 keeps it, 1 drives it low, 2 drives it high, 3 toggles it.
- R7: When compare A and compare B events fall on the same count enable, only compare B's action is applied.
- R8: Counting from 0xFF to 0x00 sets the overflow flag (flag bit 2). An interrupt output is high only while both its flag and its enable are set.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. When a flag is set and cleared on the same clock, it stays set.
- R10: In cascade mode 1, channel 0 advances only when channel 1 overflows, and its own clock select is ignored. The pair forms one 16-bit count with channel 0 as the high byte.
- R11: In cascade mode 2, channel 1 advances once on each compare-A event of channel 0, and its own clock select is ignored.
- R12: A compare-A event of a channel whose trigger enable is set gives a converter trigger that is high for exactly one system clock, on the clock after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: bit 3 selects the channel |
| wr_data | input | 8 | Register write data |
| ext_clk | input | 2 | External count clock, one bit per channel |
| ext_rst | input | 2 | External counter clear, one bit per channel |
| tmo | output | 2 | Waveform output, one bit per channel |
| irq_cma | output | 2 | Compare-A interrupt, one bit per channel |
| irq_cmb | output | 2 | Compare-B interrupt, one bit per channel |
| irq_ovf | output | 2 | Overflow interrupt, one bit per channel |
| adc_trig | output | 1 | One-cycle converter start pulse |
| cnt0 | output | 8 | Channel 0 counter value |
| cnt1 | output | 8 | Channel 1 counter value |

## Verification
The bench steps the external clock pin one edge at a time, so every compare, clear and overflow lands on a known count. Three corner cases get particular attention:
- Equal compare values, checked with actions that disagree. A design that let compare A win would leave the pin low.
- A flag clear written on the exact clock the overflow sets the flag. A design where the clear wins would drop the interrupt.
- Each cascade mode with the ignored clock select set to a fast tap. A design that kept honouring that select would run the high byte on its own.

Prescaler rates are measured over windows that are whole multiples of the tap period, so the count delta is exact whatever the divider phase.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int TMR_W   = 8;
  localparam int ADDR_W  = 4;
  localparam int NUM_CH  = 2;
  localparam int NUM_TAP = 6;
  localparam int FLAG_W  = 3;

  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_WAVE = 3'd1;
  localparam logic [2:0] OFF_CMPA = 3'd2;
  localparam logic [2:0] OFF_CMPB = 3'd3;
  localparam logic [2:0] OFF_CASC = 3'd4;
  localparam logic [2:0] OFF_FLAG = 3'd5;
  localparam logic [2:0] OFF_CNT  = 3'd6;

  localparam logic [2:0] SEL_STOP = 3'd0;
  localparam logic [2:0] SEL_EXT  = 3'd7;

  typedef enum logic [1:0] {CLR_NONE, CLR_A, CLR_B, CLR_EXT} clr_sel_e;
  typedef enum logic [1:0] {ACT_KEEP, ACT_LOW, ACT_HIGH, ACT_TOGGLE} wave_act_e;
  typedef enum logic [1:0] {CASC_OFF, CASC_WIDE, CASC_EVCNT, CASC_RSV} casc_e;

  typedef struct packed {
    logic [2:0]        clk_sel;
    clr_sel_e          clr_sel;
    logic [FLAG_W-1:0] ie;
    wave_act_e         act_a;
    wave_act_e         act_b;
    logic              adc_en;
    logic [TMR_W-1:0]  cmp_a;
    logic [TMR_W-1:0]  cmp_b;
  } chan_cfg_t;
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int NTAP = 6,
  parameter int DIV_W = 13,
  parameter int TAP_SHIFT [NTAP] = '{1, 3, 5, 6, 10, 13}
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NTAP-1:0] tap
);
  logic [DIV_W-1:0] div_q, div_d;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap[k] = &div_q[TAP_SHIFT[k]-1:0];
    if (k > 0) begin : g_nest
      // a slower tap only fires together with every faster one
      assert_tap_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tap[k] |-> tap[k-1]);
    end
  end
endmodule

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= async_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;

  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs import tmr8_pkg::*; (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [TMR_W-1:0]              wr_data,
  output chan_cfg_t [NUM_CH-1:0]        cfg,
  output casc_e                         casc,
  output logic [NUM_CH-1:0][FLAG_W-1:0] flag_clr,
  output logic [NUM_CH-1:0]             cnt_wr
);
  localparam int OFF_W = ADDR_W - 1;

  logic [OFF_W-1:0] off;
  casc_e casc_q, casc_d;

  assign off = wr_addr[OFF_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    chan_cfg_t cfg_q, cfg_d;
    logic      hit;

    assign hit = wr_en && (wr_addr[ADDR_W-1] == 1'(c));

    always_comb begin
      cfg_d       = cfg_q;
      flag_clr[c] = '0;
      cnt_wr[c]   = 1'b0;
      if (hit) begin
        case (off)
          OFF_CTRL: begin
            cfg_d.clk_sel = wr_data[2:0];
            cfg_d.clr_sel = clr_sel_e'(wr_data[4:3]);
            cfg_d.ie      = wr_data[7:5];
          end
          OFF_WAVE: begin
            cfg_d.act_a  = wave_act_e'(wr_data[1:0]);
            cfg_d.act_b  = wave_act_e'(wr_data[3:2]);
            cfg_d.adc_en = wr_data[4];
          end
          OFF_CMPA: cfg_d.cmp_a = wr_data;
          OFF_CMPB: cfg_d.cmp_b = wr_data;
          OFF_FLAG: flag_clr[c] = wr_data[FLAG_W-1:0];
          OFF_CNT:  cnt_wr[c]   = 1'b1;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_d;
    end

    assign cfg[c] = cfg_q;
  end

  always_comb begin
    casc_d = casc_q;
    if (wr_en && !wr_addr[ADDR_W-1] && off == OFF_CASC) casc_d = casc_e'(wr_data[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) casc_q <= CASC_OFF;
    else        casc_q <= casc_d;
  end

  assign casc = casc_q;
endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel import tmr8_pkg::*; #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ext_clr,
  input  logic              cnt_wr,
  input  logic [W-1:0]      cnt_wdata,
  input  logic [W-1:0]      cmp_a,
  input  logic [W-1:0]      cmp_b,
  input  clr_sel_e          clr_sel,
  input  wave_act_e         act_a,
  input  wave_act_e         act_b,
  input  logic [FLAG_W-1:0] flag_clr,
  input  logic [FLAG_W-1:0] ie,
  output logic [W-1:0]      cnt,
  output logic              match_a,
  output logic              ovf,
  output logic              tmo,
  output logic [FLAG_W-1:0] irq
);
  logic [W-1:0]      cnt_q, cnt_d;
  logic              tmo_q, tmo_d;
  logic [FLAG_W-1:0] flag_q, flag_d;
  logic              match_b, clr_hit;

  function automatic logic wave_next(wave_act_e act, logic cur);
    case (act)
      ACT_LOW:    wave_next = 1'b0;
      ACT_HIGH:   wave_next = 1'b1;
      ACT_TOGGLE: wave_next = ~cur;
      default:    wave_next = cur;
    endcase
  endfunction

  always_comb begin
    match_a = tick && (cnt_q == cmp_a);
    match_b = tick && (cnt_q == cmp_b);
    clr_hit = (clr_sel == CLR_A && match_a) || (clr_sel == CLR_B && match_b);
    ovf     = tick && !clr_hit && (cnt_q == {W{1'b1}});

    cnt_d = cnt_q;
    if (cnt_wr)                              cnt_d = cnt_wdata;
    else if (ext_clr && clr_sel == CLR_EXT)  cnt_d = '0;
    else if (tick)                           cnt_d = clr_hit ? '0 : cnt_q + 1'b1;

    tmo_d = tmo_q;
    if (match_b)      tmo_d = wave_next(act_b, tmo_q);
    else if (match_a) tmo_d = wave_next(act_a, tmo_q);

    flag_d = (flag_q & ~flag_clr) | {ovf, match_b, match_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tmo_q  <= 1'b0;
      flag_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      tmo_q  <= tmo_d;
      flag_q <= flag_d;
    end
  end

  assign cnt = cnt_q;
  assign tmo = tmo_q;
  assign irq = flag_q & ie;

  assert_clear_on_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_sel == CLR_A && cnt_q == cmp_a && !cnt_wr) |=> cnt_q == '0);

  assert_b_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == cmp_a && cnt_q == cmp_b && act_b == ACT_HIGH) |=> tmo_q);

  assert_flag_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_sel == CLR_NONE && cnt_q == {W{1'b1}}) |=> flag_q[2]);

  assert_match_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |=> !match_a);
endmodule

// File: rtl/tmr8_dual.sv
module tmr8_dual import tmr8_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [TMR_W-1:0]    wr_data,
  input  logic [NUM_CH-1:0]   ext_clk,
  input  logic [NUM_CH-1:0]   ext_rst,
  output logic [NUM_CH-1:0]   tmo,
  output logic [NUM_CH-1:0]   irq_cma,
  output logic [NUM_CH-1:0]   irq_cmb,
  output logic [NUM_CH-1:0]   irq_ovf,
  output logic                adc_trig,
  output logic [TMR_W-1:0]    cnt0,
  output logic [TMR_W-1:0]    cnt1
);
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  chan_cfg_t [NUM_CH-1:0]        cfg;
  casc_e                         casc;
  logic [NUM_CH-1:0][FLAG_W-1:0] flag_clr;
  logic [NUM_CH-1:0]             cnt_wr;
  logic [NUM_TAP-1:0]            taps;
  logic [NUM_CH-1:0]             clk_rise, clr_rise;

  tmr8_regs u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .casc(casc), .flag_clr(flag_clr), .cnt_wr(cnt_wr)
  );

  tmr8_prescaler #(.NTAP(NUM_TAP)) u_pre (.clk(clk), .rst_n(rst_q), .tap(taps));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
    tmr8_edge_sync u_clk_sync (.clk(clk), .rst_n(rst_q), .async_in(ext_clk[c]), .rise(clk_rise[c]));
    tmr8_edge_sync u_clr_sync (.clk(clk), .rst_n(rst_q), .async_in(ext_rst[c]), .rise(clr_rise[c]));
  end

  function automatic logic pick_src(logic [2:0] sel, logic [NUM_TAP-1:0] tp, logic ext);
    if (sel == SEL_STOP)     pick_src = 1'b0;
    else if (sel == SEL_EXT) pick_src = ext;
    else                     pick_src = tp[sel - 3'd1];
  endfunction

  logic src0, src1, cm_evt, tick0, tick1;
  logic match_a0, match_a1, ovf0, ovf1;
  logic [FLAG_W-1:0] irq0, irq1;
  logic adc_q, adc_d;

  always_comb begin
    src0   = pick_src(cfg[0].clk_sel, taps, clk_rise[0]);
    src1   = pick_src(cfg[1].clk_sel, taps, clk_rise[1]);
    cm_evt = src0 && (cnt0 == cfg[0].cmp_a);
    tick1  = (casc == CASC_EVCNT) ? cm_evt : src1;
    tick0  = (casc == CASC_WIDE)  ? ovf1   : src0;
  end

  tmr8_channel #(.W(TMR_W)) u_ch0 (
    .clk(clk), .rst_n(rst_q), .tick(tick0), .ext_clr(clr_rise[0]),
    .cnt_wr(cnt_wr[0]), .cnt_wdata(wr_data), .cmp_a(cfg[0].cmp_a), .cmp_b(cfg[0].cmp_b),
    .clr_sel(cfg[0].clr_sel), .act_a(cfg[0].act_a), .act_b(cfg[0].act_b),
    .flag_clr(flag_clr[0]), .ie(cfg[0].ie),
    .cnt(cnt0), .match_a(match_a0), .ovf(ovf0), .tmo(tmo[0]), .irq(irq0)
  );

  tmr8_channel #(.W(TMR_W)) u_ch1 (
    .clk(clk), .rst_n(rst_q), .tick(tick1), .ext_clr(clr_rise[1]),
    .cnt_wr(cnt_wr[1]), .cnt_wdata(wr_data), .cmp_a(cfg[1].cmp_a), .cmp_b(cfg[1].cmp_b),
    .clr_sel(cfg[1].clr_sel), .act_a(cfg[1].act_a), .act_b(cfg[1].act_b),
    .flag_clr(flag_clr[1]), .ie(cfg[1].ie),
    .cnt(cnt1), .match_a(match_a1), .ovf(ovf1), .tmo(tmo[1]), .irq(irq1)
  );

  assign irq_cma = {irq1[0], irq0[0]};
  assign irq_cmb = {irq1[1], irq0[1]};
  assign irq_ovf = {irq1[2], irq0[2]};

  always_comb adc_d = (match_a0 && cfg[0].adc_en) || (match_a1 && cfg[1].adc_en);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) adc_q <= 1'b0;
    else        adc_q <= adc_d;
  end
  assign adc_trig = adc_q;

  // R10: high byte holds still between carries from the low byte
  assert_wide_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (casc == CASC_WIDE && !ovf1 && !wr_en && !clr_rise[0]) |=> $stable(cnt0));

  assert_wide_wrap_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (ovf0 && !cnt_wr[0]) |=> cnt0 == '0);

  assert_event_count_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (casc == CASC_EVCNT && cm_evt && !wr_en && cfg[1].clr_sel == CLR_NONE)
      |=> cnt1 == $past(cnt1) + 1'b1);
endmodule

// File: tb/tmr8_dual_test.sv
module tmr8_dual_test;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] ext_clk, ext_rst;
  logic [1:0] tmo, irq_cma, irq_cmb, irq_ovf;
  logic adc_trig;
  logic [7:0] cnt0, cnt1;

  int checks = 0;
  int fails = 0;
  int adc_pulses = 0;
  int adc_wide = 0;
  logic adc_prev = 1'b0;

  localparam logic [3:0] CH1 = 4'd8;

  always #10 clk = ~clk;

  tmr8_dual uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk(ext_clk), .ext_rst(ext_rst), .tmo(tmo), .irq_cma(irq_cma),
    .irq_cmb(irq_cmb), .irq_ovf(irq_ovf), .adc_trig(adc_trig), .cnt0(cnt0), .cnt1(cnt1)
  );

  always @(negedge clk) begin
    if (adc_trig) adc_pulses++;
    if (adc_trig && adc_prev) adc_wide++;
    adc_prev = adc_trig;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ext_step(int ch);
    ext_clk[ch] = 1'b1;
    repeat (3) @(negedge clk);
    ext_clk[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ext_clear(int ch);
    ext_rst[ch] = 1'b1;
    repeat (3) @(negedge clk);
    ext_rst[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 cnt0", cnt0, 0);
    check("R1 cnt1", cnt1, 0);
    check("R1 tmo", tmo, 0);
    check("R1 irq", {irq_cma, irq_cmb, irq_ovf}, 0);
    check("R1 adc", adc_trig, 0);
  endtask

  task automatic t_prescale;
    int divs [4] = '{2, 8, 32, 64};
    for (int i = 0; i < 4; i++) begin
      logic [7:0] start, delta;
      wr(4'd6, 8'd0);
      wr(4'd0, 8'(i + 1));
      start = cnt0;
      repeat (divs[i] * 8) @(negedge clk);
      delta = cnt0 - start;
      check($sformatf("R2 div%0d", divs[i]), delta, 8);
    end
    wr(4'd0, 8'd0);
    begin
      logic [7:0] held;
      held = cnt0;
      repeat (40) @(negedge clk);
      check("R2 stopped", cnt0, held);
    end
  endtask

  task automatic t_ext;
    wr(4'd0, 8'h07);
    wr(4'd6, 8'd0);
    for (int i = 0; i < 5; i++) ext_step(0);
    check("R3 ext count", cnt0, 5);
  endtask

  task automatic t_clear;
    wr(4'd5, 8'h07);
    wr(4'd2, 8'd3);
    wr(4'd0, 8'h07 | (8'd1 << 3) | (8'd1 << 5));
    wr(4'd6, 8'd0);
    for (int i = 0; i < 3; i++) ext_step(0);
    check("R4 before A", cnt0, 3);
    check("R8 no flag yet", irq_cma[0], 0);
    ext_step(0);
    check("R4 clear on A", cnt0, 0);
    check("R8 cma irq", irq_cma[0], 1);
    ext_step(0);
    check("R4 after clear", cnt0, 1);
    wr(4'd2, 8'd1);
    wr(4'd3, 8'd2);
    wr(4'd0, 8'h07 | (8'd2 << 3));
    wr(4'd6, 8'd0);
    ext_step(0); ext_step(0);
    check("R4 A passes w/o clear", cnt0, 2);
    ext_step(0);
    check("R4 clear on B", cnt0, 0);
  endtask

  task automatic t_ext_reset;
    wr(4'd0, 8'h07 | (8'd3 << 3));
    wr(4'd6, 8'd0);
    for (int i = 0; i < 5; i++) ext_step(0);
    check("R5 counted", cnt0, 5);
    ext_clear(0);
    check("R5 ext clear", cnt0, 0);
    wr(4'd0, 8'h07);
    ext_step(0); ext_step(0);
    ext_clear(0);
    check("R5 ignored", cnt0, 2);
  endtask

  task automatic t_wave;
    wr(4'd0, 8'h07 | (8'd2 << 3));
    wr(4'd2, 8'd1);
    wr(4'd3, 8'd3);
    wr(4'd1, 8'h06);
    wr(4'd6, 8'd0);
    ext_step(0); check("R6 pwm s1", tmo[0], 0);
    ext_step(0); check("R6 pwm high", tmo[0], 1);
    ext_step(0); check("R6 pwm hold", tmo[0], 1);
    ext_step(0); check("R6 pwm low", tmo[0], 0);
    wr(4'd0, 8'h07 | (8'd1 << 3));
    wr(4'd2, 8'd0);
    wr(4'd1, 8'h03);
    wr(4'd6, 8'd0);
    ext_step(0); check("R6 toggle 1", tmo[0], 1);
    ext_step(0); check("R6 toggle 2", tmo[0], 0);
    wr(4'd0, 8'h07);
    wr(4'd2, 8'd2);
    wr(4'd3, 8'd2);
    wr(4'd1, 8'h09);
    wr(4'd6, 8'd0);
    ext_step(0); ext_step(0);
    check("R7 before", tmo[0], 0);
    ext_step(0);
    check("R7 B wins", tmo[0], 1);
  endtask

  task automatic t_flags;
    wr(4'd0, 8'h07);
    wr(4'd5, 8'h07);
    wr(4'd6, 8'hFE);
    ext_step(0);
    check("R8 at FF", cnt0, 255);
    ext_step(0);
    check("R8 wrap", cnt0, 0);
    check("R8 masked", irq_ovf[0], 0);
    wr(4'd0, 8'h87);
    check("R8 enabled", irq_ovf[0], 1);
    wr(4'd5, 8'h03);
    check("R9 zero bit keeps", irq_ovf[0], 1);
    wr(4'd5, 8'h04);
    check("R9 w1c", irq_ovf[0], 0);
    wr(4'd6, 8'hFF);
    ext_clk[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(4'd5, 8'h04);
    ext_clk[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 wrapped", cnt0, 0);
    check("R9 set wins", irq_ovf[0], 1);
    wr(4'd5, 8'h07);
    wr(4'd0, 8'h07);
  endtask

  task automatic t_wide;
    wr(4'd4, 8'd1);
    wr(CH1 | 4'd0, 8'h07);
    wr(CH1 | 4'd6, 8'hFE);
    wr(4'd6, 8'h12);
    wr(4'd0, 8'h01);
    ext_step(1);
    check("R10 low FF", cnt1, 255);
    check("R10 high held", cnt0, 8'h12);
    ext_step(1);
    check("R10 low wrap", cnt1, 0);
    check("R10 carry", cnt0, 8'h13);
    repeat (20) @(negedge clk);
    check("R10 own clock ignored", cnt0, 8'h13);
  endtask

  task automatic t_evcount;
    int base;
    wr(4'd4, 8'd2);
    wr(4'd0, 8'h07 | (8'd1 << 3));
    wr(4'd2, 8'd1);
    wr(4'd1, 8'h10);
    wr(4'd6, 8'd0);
    wr(CH1 | 4'd0, 8'h01);
    wr(CH1 | 4'd6, 8'd0);
    base = adc_pulses;
    for (int i = 0; i < 4; i++) ext_step(0);
    check("R11 events", cnt1, 2);
    check("R12 pulses", adc_pulses - base, 2);
    check("R12 width", adc_wide, 0);
    wr(4'd1, 8'h00);
    base = adc_pulses;
    ext_step(0); ext_step(0);
    check("R11 third", cnt1, 3);
    check("R12 disabled", adc_pulses - base, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ext_clk = '0; ext_rst = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_prescale;
    t_ext;
    t_clear;
    t_ext_reset;
    t_wave;
    t_flags;
    t_wide;
    t_evcount;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule